// File: doc/BRIEF.md
# Refresh interval scheduler

This block paces the refresh traffic of a dynamic-cell memory. A free-running interval timer produces one refresh demand per fixed period; each demand is added to a small pending count. While anything is pending, the block raises a request toward the access sequencer. The sequencer is free to serve host traffic first and answer the request later, and every acknowledge retires one pending refresh. The count saturates at a limit, and an overdue flag shows that the backlog has reached that limit.

Two refresh styles are supported. In row-addressed mode, the block supplies the row to refresh on an 8-bit output. That output is meant for the low address bits of the memory; the upper address bits are don't-care. The row advances on each acknowledge and wraps from 255 to 0. In self-addressed mode, the memory counts rows internally, so the row output holds still and the block only paces requests.

After each acknowledge the request is held off for a guard of a few cycles. This keeps back-to-back refreshes apart by at least the memory's minimum refresh cycle time. At the default 50 MHz clock a demand arrives every 750 cycles (15 µs). That leaves margin below the 15.6 µs average needed for 256 rows in 4 ms.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, and on the first falling edge after it is released, req is 0, overdue is 0 and row_addr is 0. Reset also clears the interval timer.
- R2: With ack held at 0 after reset, req first reads 1 exactly INTERVAL clock edges after reset is released. From then on one refresh demand is added every INTERVAL cycles, whether or not acknowledges occur.
- R3: The pending count rises by one on each demand and falls by one on each accepted acknowledge; when both happen on the same edge it is unchanged. req is 1 exactly while the count is nonzero and no guard is running, and a raised req stays high until it is acknowledged.
- R4: overdue is 1 exactly when the pending count equals PEND_MAX. A demand that arrives at the limit without an acknowledge on the same edge is not counted, and overdue stays 1.
- R5: An ack given while req is 0 is ignored: it changes neither row_addr nor the pending count, and it starts no guard.
- R6: With auto_mode = 0 (row-addressed refresh), each accepted acknowledge advances row_addr by one on that edge, and row_addr wraps from 2^ROW_W-1 to 0.
- R7: With auto_mode = 1 (self-addressed refresh), row_addr holds its value through acknowledges, while the pending count still falls by one per accepted acknowledge.
- R8: After an accepted acknowledge, req is 0 for the next MIN_GAP cycles, even if refreshes are still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_mode | input | 1 | 0 = row-addressed refresh, 1 = self-addressed refresh |
| ack | input | 1 | Acknowledge from the access sequencer; accepted only while req is 1 |
| req | output | 1 | Refresh request |
| row_addr | output | ROW_W | Row to refresh, for the low address bits |
| overdue | output | 1 | Pending count is at its limit |

## Verification
Every output is decoded from registered state, so an acknowledge or timer demand on one rising edge is visible right after that edge. The one exception is the first request, which appears INTERVAL edges after reset is released. The bench drives inputs on the falling edge and compares the outputs on the next falling edge against a model stepped once per edge, so each result is checked in the cycle it is due. Directed checks also measure the delay to the first request and observe the row wrap, the saturation point and the guard window at those exact cycles.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic {
        MODE_ROW_ADDR  = 1'b0,
        MODE_SELF_ADDR = 1'b1
    } rfs_mode_e;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int INTERVAL = 750
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;
    logic at_end;

    always_comb begin
        s_d    = s_q;
        at_end = (s_q.cnt == TW'(INTERVAL - 1));
        if (at_end) s_d.cnt = '0;
        else        s_d.cnt = s_q.cnt + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = at_end;
endmodule

// File: rtl/rfs_pending_ctr.sv
module rfs_pending_ctr #(
    parameter int PEND_MAX = 4,
    parameter int MIN_GAP  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ack,
    output logic req,
    output logic accept,
    output logic overdue
);
    localparam int PW = $clog2(PEND_MAX + 1);
    localparam int GW = $clog2(MIN_GAP + 1);

    typedef struct packed {
        logic [PW-1:0] pend;
        logic [GW-1:0] gap;
    } pc_t;

    pc_t  s_d, s_q;
    logic at_lim;
    logic req_i;
    logic acc_i;

    always_comb begin
        s_d    = s_q;
        at_lim = (s_q.pend == PW'(PEND_MAX));
        req_i  = (s_q.pend != '0) && (s_q.gap == '0);
        acc_i  = req_i && ack;
        unique case ({tick, acc_i})
            2'b10:   if (!at_lim) s_d.pend = s_q.pend + PW'(1);
            2'b01:   s_d.pend = s_q.pend - PW'(1);
            default: s_d.pend = s_q.pend;
        endcase
        if (acc_i)               s_d.gap = GW'(MIN_GAP);
        else if (s_q.gap != '0)  s_d.gap = s_q.gap - GW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req     = req_i;
    assign accept  = acc_i;
    assign overdue = at_lim;
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr
    import rfs_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rfs_mode_e        mode,
    input  logic             accept,
    output logic [ROW_W-1:0] row
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
    } rc_t;

    rc_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (accept && (mode == MODE_ROW_ADDR))
            s_d.row = s_q.row + ROW_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign row = s_q.row;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import rfs_pkg::*;
#(
    parameter int INTERVAL = 750,
    parameter int ROW_W    = 8,
    parameter int PEND_MAX = 4,
    parameter int MIN_GAP  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_mode,
    input  logic             ack,
    output logic             req,
    output logic [ROW_W-1:0] row_addr,
    output logic             overdue
);
    logic tick;
    logic accept;

    rfs_interval_timer #(.INTERVAL(INTERVAL)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rfs_pending_ctr #(.PEND_MAX(PEND_MAX), .MIN_GAP(MIN_GAP)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ack     (ack),
        .req     (req),
        .accept  (accept),
        .overdue (overdue)
    );

    rfs_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (rfs_mode_e'(auto_mode)),
        .accept (accept),
        .row    (row_addr)
    );
endmodule

module refresh_sched_chk #(
    parameter int ROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             auto_mode,
    input logic             ack,
    input logic             req,
    input logic [ROW_W-1:0] row_addr,
    input logic             overdue
);
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        req && !ack |=> req);

    a_r4_overdue_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overdue && !(req && ack) |=> overdue);

    a_r5_idle_ack_no_row_move: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(row_addr));

    a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        req && ack && !auto_mode |=> row_addr == $past(row_addr) + ROW_W'(1));

    a_r7_self_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        auto_mode |=> $stable(row_addr));

    a_r8_guard_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        req && ack |=> !req);
endmodule

bind refresh_sched refresh_sched_chk #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_mode (auto_mode),
    .ack       (ack),
    .req       (req),
    .row_addr  (row_addr),
    .overdue   (overdue)
);

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
    localparam int INTERVAL = 20;
    localparam int ROW_W    = 8;
    localparam int PEND_MAX = 4;
    localparam int MIN_GAP  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             auto_mode = 1'b0;
    logic             ack = 1'b0;
    logic             req;
    logic [ROW_W-1:0] row_addr;
    logic             overdue;

    int n_chk  = 0;
    int n_fail = 0;

    int m_tmr, m_pend, m_gap, m_row;
    bit wrap_seen;
    bit done = 1'b0;

    always #4 clk = ~clk;

    refresh_sched #(.INTERVAL(INTERVAL), .ROW_W(ROW_W), .PEND_MAX(PEND_MAX),
                    .MIN_GAP(MIN_GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .ack(ack),
        .req(req), .row_addr(row_addr), .overdue(overdue));

    function automatic bit exp_req();
        return (m_pend != 0) && (m_gap == 0);
    endfunction

    function automatic bit exp_ovd();
        return m_pend == PEND_MAX;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tmr = 0; m_pend = 0; m_gap = 0; m_row = 0;
    endtask

    // one edge of the spec model, using the inputs now driven
    task automatic model_edge(input bit a, input bit m);
        bit tk, acc;
        tk  = (m_tmr == INTERVAL - 1);
        acc = exp_req() && a;
        m_tmr = tk ? 0 : m_tmr + 1;
        if (tk && !acc && m_pend < PEND_MAX) m_pend++;
        else if (!tk && acc)                 m_pend--;
        if (acc)             m_gap = MIN_GAP;
        else if (m_gap != 0) m_gap--;
        if (acc && !m) begin
            if (m_row == (1 << ROW_W) - 1) begin m_row = 0; wrap_seen = 1'b1; end
            else m_row++;
        end
    endtask

    // compare at falling edge, drive, advance model, wait next falling edge
    task automatic step(input bit a, input bit m, input string rq);
        chk(req === exp_req(), rq, "req", int'(req), int'(exp_req()));
        chk(row_addr === ROW_W'(m_row), rq, "row_addr", int'(row_addr), m_row);
        chk(overdue === exp_ovd(), rq, "overdue", int'(overdue), int'(exp_ovd()));
        ack = a; auto_mode = m;
        model_edge(a, m);
        @(negedge clk);
    endtask

    initial begin
        int first_req;
        int row_before;
        void'($urandom(32'd20240611));
        model_reset();
        wrap_seen = 1'b0;
        repeat (3) @(negedge clk);
        chk(req === 1'b0 && overdue === 1'b0 && row_addr === '0, "R1",
            "reset outputs", int'({req, overdue}), 0);
        rst_n = 1'b1;

        // R1 and R2: first request timing
        first_req = -1;
        for (int k = 0; k <= INTERVAL + 1; k++) begin
            if (req === 1'b1 && first_req < 0) first_req = k;
            step(1'b0, 1'b0, (k == 0) ? "R1" : "R2");
        end
        chk(first_req == INTERVAL, "R2", "first req delay", first_req, INTERVAL);

        // R4: backlog builds to the limit and saturates
        for (int k = 0; k < INTERVAL * (PEND_MAX + 2); k++) step(1'b0, 1'b0, "R4");
        chk(overdue === 1'b1, "R4", "overdue at limit", int'(overdue), 1);

        // R3 and R8: drain with ack held, guard spacing observed
        for (int k = 0; k < 40; k++) begin
            if (ack === 1'b1 && k > 0) begin
                // previous step was an accepted ack only if model gap is now MIN_GAP
                if (m_gap == MIN_GAP)
                    chk(req === 1'b0, "R8", "req during guard", int'(req), 0);
            end
            step(1'b1, 1'b0, "R3");
        end

        // R5: ack while req is low changes nothing
        while (exp_req()) step(1'b0, 1'b0, "R5");
        while (m_pend != 0) step(1'b1, 1'b0, "R5");
        row_before = m_row;
        for (int k = 0; k < 8 && m_tmr != INTERVAL - 1; k++) step(1'b1, 1'b0, "R5");
        chk(row_addr === ROW_W'(row_before) && req === 1'b0 && m_pend == 0, "R5",
            "row after idle ack", int'(row_addr), row_before);

        // R7: self-addressed mode keeps the row
        row_before = m_row;
        for (int k = 0; k < INTERVAL * 8; k++) step(($urandom % 2) == 0, 1'b1, "R7");
        chk(row_addr === ROW_W'(row_before), "R7", "row in self mode",
            int'(row_addr), row_before);

        // random mix, R3 and R6
        for (int k = 0; k < 3000; k++)
            step(($urandom % 4) == 0, ((k / 500) % 2) == 1, "R3");

        // R6: run through the row wrap
        wrap_seen = 1'b0;
        for (int k = 0; k < INTERVAL * 300 && !wrap_seen; k++) step(1'b1, 1'b0, "R6");
        chk(wrap_seen, "R6", "row wrap observed", int'(wrap_seen), 1);
        step(1'b0, 1'b0, "R6");
        chk(row_addr === '0 || wrap_seen, "R6", "row after wrap", int'(row_addr), m_row);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule